// File: doc/BRIEF.md
# Iterative Fibonacci Term Generator

This block computes one term of the Fibonacci sequence on request. A caller places an index on `index` and pulses `start`. The block then steps the recurrence one addition per clock cycle, using two registers that hold the two most recent terms. When it reaches the requested term, it raises `done` and presents the value on `result`. No table of precomputed terms exists anywhere in the block. The number of iterations is set by a step counter compared against the latched index. It is not set by any structural loop.

The block is meant to sit behind a simple request/complete handshake. `done` and `result` stay put until the caller issues the next request, so a slow consumer can read the value at any later time. Indices from 0 to 23 are supported. The largest term, F(23) = 28657 (0x6FF1), fits in the 16-bit result.

Top module: `fib_iter_calc`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `done` is 0 and `result` is 0.
- R2: A clock edge with `start` high while no computation is running latches `index` and starts a computation; `done` is 0 after that edge.
- R3: The value presented with `done` equals F(n) for the latched index n, where F(0)=0, F(1)=1 and F(k)=F(k-1)+F(k-2); for n=23 it is 16'h6FF1.
- R4: `done` rises exactly n+1 clock edges after the edge that latched index n (so index 0 takes 1 cycle and index 1 takes 2).
- R5: Once `done` is high, `done` stays high and `result` keeps its value on every edge where `start` is low.
- R6: While a computation is running, `start` pulses and changes on `index` have no effect on the result or on when it appears.
- R7: A `start` pulse while `done` is high begins a new computation with the new index.
- R8: Driving `rst_n` low during a computation aborts it: `done` and `result` go to 0 at once, and a later request runs normally.
- R9: `result` changes only on the edge where `done` rises, or under reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; sampled while idle or holding a result |
| index | input | IDX_W (5) | Index of the requested term, 0 to 23 |
| done | output | 1 | High while a finished result is held |
| result | output | RES_W (16) | Fibonacci term of the latched index |

## Verification
After the edge that samples `start`, `done` is due exactly n+1 edges later, and `result` changes on that same edge. Before then, both outputs keep their previous values or their reset values. The bench runs a behavioural countdown model that is advanced on every rising edge. The model is compared with the outputs on every falling edge, half a cycle after each register update, so an early or late result shows up as a mismatch in that specific cycle. Each request also measures the latency in edges and compares it with n+1. The bench sweeps every index from 0 to 23, and covers a hold window, interference while busy, and a reset in mid-run.

// File: rtl/fib_iter_calc.sv
module fib_iter_calc #(
  parameter int IDX_W = 5,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] index,
  output logic             done,
  output logic [RES_W-1:0] result
);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_CALC = 2'd1, S_HOLD = 2'd2} state_t;

  state_t           state;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] step_q;
  logic [RES_W-1:0] lo_q;
  logic [RES_W-1:0] hi_q;
  logic [RES_W-1:0] res_q;

  wire [RES_W-1:0] sum  = lo_q + hi_q;
  wire             last = (step_q == idx_q);
  wire             take = start && (state != S_CALC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      idx_q  <= '0;
      step_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      res_q  <= '0;
    end else begin
      case (state)
        S_CALC: begin
          if (last) begin
            res_q <= lo_q;
            state <= S_HOLD;
          end else begin
            lo_q   <= hi_q;
            hi_q   <= sum;
            step_q <= step_q + 1'b1;
          end
        end
        default: begin
          if (take) begin
            idx_q  <= index;
            step_q <= '0;
            lo_q   <= '0;
            hi_q   <= {{(RES_W-1){1'b0}}, 1'b1};
            state  <= S_CALC;
          end
        end
      endcase
    end
  end

  assign done   = (state == S_HOLD);
  assign result = res_q;

endmodule

// File: rtl/fib_iter_calc_chk.sv
module fib_iter_calc_chk #(
  parameter int IDX_W = 5,
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic [RES_W-1:0] result,
  input logic [1:0]       st,
  input logic [IDX_W-1:0] idx_q,
  input logic [IDX_W-1:0] step_q
);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st != 2'd1) |=> (!done && st == 2'd1));

  assert_max_term_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && idx_q == 5'd23) |-> (result == 16'h6FF1));

  assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |-> (step_q <= idx_q));

  assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(result)));

  assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |=> $stable(idx_q));

  assert_result_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) |-> $stable(result));

endmodule

bind fib_iter_calc fib_iter_calc_chk #(.IDX_W(IDX_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .result(result),
  .st(state), .idx_q(idx_q), .step_q(step_q)
);

// File: tb/tb_fib_iter_calc.sv
module tb_fib_iter_calc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  index = '0;
  logic        done;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fib_iter_calc dut (.clk(clk), .rst_n(rst_n), .start(start), .index(index),
                     .done(done), .result(result));

  function automatic int fib(input int n);
    int a = 0;
    int b = 1;
    for (int i = 0; i < n; i++) begin
      int t = a + b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_busy, m_done;
  int m_left, m_res, m_tgt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_res = 0; m_left = 0; m_tgt = 0;
    end else if (m_busy) begin
      if (m_left == 0) begin
        m_busy = 0; m_done = 1; m_res = m_tgt;
      end else m_left--;
    end else if (start) begin
      m_busy = 1; m_done = 0; m_left = index; m_tgt = fib(index);
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      chk(done == m_done, "R4 done per cycle", done, m_done);
      chk(result == m_res[15:0], "R9 result per cycle", result, m_res);
    end
  end

  task automatic run(input int n, input string req);
    int cyc = 0;
    @(negedge clk);
    start = 1'b1; index = 5'(n);
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R2 done low after request", done, 0);
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == n + 1, {req, " latency R4"}, cyc, n + 1);
    chk(result == 16'(fib(n)), {req, " value R3"}, result, fib(n));
  endtask

  initial begin
    #2000000;
    chk(0, "watchdog", 0, 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #12;
    chk(done == 0 && result == 0, "R1 reset state", result, 0);
    #20 rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && result == 0, "R1 after release", result, 0);

    for (int n = 0; n <= 23; n++) run(n, "R7 sweep");
    chk(result == 16'h6FF1, "R3 index 23", result, 16'h6FF1);

    // hold window
    repeat (6) @(negedge clk);
    chk(done && result == 16'h6FF1, "R5 hold", result, 16'h6FF1);

    // interference while busy
    @(negedge clk);
    start = 1'b1; index = 5'd10;
    @(negedge clk);
    start = 1'b0; index = 5'd3;
    repeat (3) @(negedge clk);
    start = 1'b1; index = 5'd4;
    @(negedge clk);
    start = 1'b0;
    begin
      int cyc = 4;
      while (!done && cyc < 40) begin
        @(negedge clk);
        cyc++;
      end
      chk(cyc == 11, "R6 latency unaffected", cyc, 11);
      chk(result == 16'd55, "R6 value unaffected", result, 55);
    end

    // reset mid-run
    @(negedge clk);
    start = 1'b1; index = 5'd15;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b0;
    #1 chk(done == 0 && result == 0, "R8 abort clears", result, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run(6, "R8 after abort");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule